// File: doc/BRIEF.md
# Grouped GPIO Interrupt Service Encoder

The block collects interrupt requests from several groups of general-purpose input lines. Each group has sixteen lines. Each group has its own trigger selectors, mask bits and pending bits. A selected condition on a line sets that line's pending bit. Every unmasked pending bit drives one shared parent interrupt output.

Software reads a single read-only service word. That word names one active source as a group number and a line number. A group number of zero means nothing unmasked is pending. A handler therefore reads the service word, clears the named pending bit by writing a one to it, and reads again until the group field comes back as zero. The bench and the hardware treat group 1 as a flat 16-bit field. Its lower byte and its upper byte may be wired from two different pin banks.

The register port is a simple synchronous write with a combinational read. Bits 7:6 of the byte address select the register class. Bits 5:2 select the word inside that class. Two groups share each word.

Top module: `gpio_irq_svc_enc`

## Requirements
- R1: The service word carries the group number (1-based, so group index g reads as g+1) in bits 7:4 and the line number in bits 3:0. All other bits read 0.
- R2: When no line is both pending and unmasked, the service word reads 0 and `irq_o` is low.
- R3: The service word names the lowest group number that has an active line. Within that group it names the lowest active line.
- R4: Class bases are trigger 0x00, mask 0x40, pending 0x80 and service 0xC0. Group index g lives in the word at byte offset 4*(g/2) from its class base. Even g uses bits 15:0 and odd g uses bits 31:16.
- R5: Each block of four lines shares one 4-bit trigger code at bit 4*(line/4) of the group's half-word. The codes are 0 low level, 1 high level, 2 falling edge, 4 rising edge and 6 both edges. Any other code never sets pending.
- R6: A line is sampled on each rising clock edge. A level code sets pending on every edge where the level holds. An edge code compares the sample with the one from the previous edge. Pending is visible right after the edge that samples the condition.
- R7: A mask bit of 1 keeps its line out of `irq_o` and out of the service word. The pending bit still records the line, and the line returns once it is unmasked.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. A trigger hit in the same cycle as the clear wins, so a held level stays pending.
- R9: `irq_o` is high exactly while some unmasked line is pending. After the named line is cleared, the service word moves to the next active source.
- R10: Writes to the service word change no state. Misaligned addresses and words past the last group read 0, and writes to them are ignored.
- R11: Reset clears every pending bit, sets every trigger code to 0 and sets every mask bit. Edge history is loaded from the lines, so releasing reset creates no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_GROUPS*16 | Input lines, group index g at bits 16g+15:16g, already synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_o | output | 1 | Parent interrupt, high while any unmasked line is pending |

## Verification
A line change driven before a rising edge shows in the pending bits after that edge. `irq_o` and the service word follow in the same cycle, with no extra register stage. Register writes take effect on the edge that samples the strobe. Reads are combinational on the current address.

The bench drives all inputs on the falling edge. It compares `irq_o` and the service word with its reference model one time unit after every rising edge, after both the model and the design have updated. Directed reads sample one time unit after the falling edge that applied the address, which is one full edge after the preceding stimulus.

// File: rtl/gsvc_pkg.sv
// Shared constants, types and helpers for the grouped interrupt service encoder.
// Assumes sixteen lines per group and one 4-bit trigger code per four lines.
package gsvc_pkg;
    localparam int GRP_LINES = 16;
    localparam int TRIG_SPAN = 4;
    localparam int TRIG_W    = 4;
    localparam int FIELD_W   = 4;
    localparam int WORD_W    = 32;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LOW  = 4'd0,
        TRIG_HIGH = 4'd1,
        TRIG_FALL = 4'd2,
        TRIG_RISE = 4'd4,
        TRIG_BOTH = 4'd6
    } trig_e;

    typedef enum logic [1:0] {
        CLS_CON  = 2'd0,
        CLS_MASK = 2'd1,
        CLS_PEND = 2'd2,
        CLS_SVC  = 2'd3
    } reg_cls_e;

    typedef struct packed {
        logic [FIELD_W-1:0] grp;
        logic [FIELD_W-1:0] line;
    } svc_t;

    // Decide whether one line's trigger condition holds this cycle.
    function automatic logic trig_fire(input logic [TRIG_W-1:0] code,
                                       input logic cur, input logic prev);
        logic hit;
        case (code)
            TRIG_LOW:  hit = !cur;
            TRIG_HIGH: hit = cur;
            TRIG_FALL: hit = prev && !cur;
            TRIG_RISE: hit = !prev && cur;
            TRIG_BOTH: hit = prev ^ cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Index of the lowest set bit of a group's field (0 when none is set).
    function automatic logic [FIELD_W-1:0] lowest_set(input logic [GRP_LINES-1:0] v);
        logic [FIELD_W-1:0] idx;
        idx = '0;
        for (int i = GRP_LINES - 1; i >= 0; i--) begin
            if (v[i]) idx = FIELD_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/gsvc_trig.sv
// Trigger detector for one group of lines.
// Keeps the previous sample of each line and applies the shared 4-bit code of
// its four-line block. The lines are assumed synchronous to clk. Because the
// history register loads on every edge, including edges in reset, leaving
// reset never looks like an edge.
module gsvc_trig
    import gsvc_pkg::*;
#(
    parameter int LINES = GRP_LINES
) (
    input  logic                               clk,
    input  logic [LINES-1:0]                   lines,
    input  logic [(LINES/TRIG_SPAN)*TRIG_W-1:0] cfg,
    output logic [LINES-1:0]                   fire
);
    logic [LINES-1:0] prev_q;

    // Capture the previous sample of every line for edge comparison.
    always_ff @(posedge clk) begin
        prev_q <= lines;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam int BLK = i / TRIG_SPAN;
        // Evaluate the block's shared trigger code for this line.
        assign fire[i] = trig_fire(cfg[BLK*TRIG_W +: TRIG_W], lines[i], prev_q[i]);
    end
endmodule

// File: rtl/gsvc_grp_regs.sv
// Trigger, mask and pending storage for one group.
// A trigger hit sets pending whether or not the line is masked, and a hit wins
// over a write-one clear in the same cycle. Reset masks every line.
module gsvc_grp_regs
    import gsvc_pkg::*;
#(
    parameter int LINES = GRP_LINES
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [LINES-1:0]                    fire,
    input  logic [LINES-1:0]                    wdata,
    input  logic                                cfg_we,
    input  logic                                mask_we,
    input  logic                                pend_we,
    output logic [(LINES/TRIG_SPAN)*TRIG_W-1:0] cfg_q,
    output logic [LINES-1:0]                    mask_q,
    output logic [LINES-1:0]                    pend_q
);
    localparam int CFG_W = (LINES / TRIG_SPAN) * TRIG_W;

    logic [LINES-1:0] clr;

    // Select the bits a pending write asks to clear.
    assign clr = pend_we ? wdata : '0;

    // Hold the trigger codes, written as a whole half-word.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= CFG_W'(wdata);
    end

    // Hold the mask bits; reset leaves every line masked.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= wdata;
    end

    // Latch trigger hits and apply write-one clears, with hits taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | fire;
    end
endmodule

// File: rtl/gsvc_prio.sv
// Fixed-priority service encoder.
// Picks the lowest group that has an active line, then that group's lowest
// active line. Output group 0 means nothing is active. Assumes
// NUM_GROUPS <= 15 so the group number fits its field.
module gsvc_prio
    import gsvc_pkg::*;
#(
    parameter int NUM_GROUPS = 4
) (
    input  logic [NUM_GROUPS*GRP_LINES-1:0] active,
    output svc_t                            svc
);
    logic [NUM_GROUPS-1:0] grp_busy;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_busy
        // Flag a group that has any active line.
        assign grp_busy[g] = |active[g*GRP_LINES +: GRP_LINES];
    end

    // Choose the lowest busy group and encode its lowest active line.
    always_comb begin
        int sel;
        sel = 0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (grp_busy[g]) sel = g;
        end
        if (|grp_busy) begin
            svc.grp  = FIELD_W'(sel + 1);
            svc.line = lowest_set(active[sel*GRP_LINES +: GRP_LINES]);
        end else begin
            svc.grp  = '0;
            svc.line = '0;
        end
    end
endmodule

// File: rtl/gpio_irq_svc_enc.sv
// Grouped GPIO interrupt service encoder, top level.
// Decodes the register port, instantiates one trigger detector and one
// register set per group, merges the active lines into the parent interrupt,
// and exposes the service word. Assumes line_in is synchronous to clk,
// NUM_GROUPS <= 15 and ADDR_W >= 6.
module gpio_irq_svc_enc
    import gsvc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_GROUPS*GRP_LINES-1:0] line_in,
    input  logic                            reg_we,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [WORD_W-1:0]               reg_wdata,
    output logic [WORD_W-1:0]               reg_rdata,
    output logic                            irq_o
);
    localparam int TOTAL  = NUM_GROUPS * GRP_LINES;
    localparam int WIDX_W = ADDR_W - 4;
    localparam int HALF_W = WORD_W / 2;
    localparam int CFG_W  = (GRP_LINES / TRIG_SPAN) * TRIG_W;

    reg_cls_e           cls;
    logic [WIDX_W-1:0]  widx;
    logic               aligned;
    logic [TOTAL-1:0]   pend_flat;
    logic [TOTAL-1:0]   mask_flat;
    logic [TOTAL-1:0]   con_flat;
    logic [TOTAL-1:0]   fire_flat;
    logic [TOTAL-1:0]   active;
    svc_t               svc;
    logic [FIELD_W-1:0] svc_grp;
    logic [FIELD_W-1:0] svc_line;

    // Split the byte address into class, word index and alignment.
    assign cls     = reg_cls_e'(reg_addr[ADDR_W-1 -: 2]);
    assign widx    = reg_addr[ADDR_W-3:2];
    assign aligned = (reg_addr[1:0] == 2'b00);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam logic [WIDX_W-1:0] MY_WORD = WIDX_W'(g / 2);
        localparam int                HALF    = g % 2;
        logic wsel;

        // Select this group when an aligned write targets its shared word.
        assign wsel = reg_we && aligned && (widx == MY_WORD);

        gsvc_trig #(.LINES(GRP_LINES)) u_trig (
            .clk   (clk),
            .lines (line_in[g*GRP_LINES +: GRP_LINES]),
            .cfg   (con_flat[g*CFG_W +: CFG_W]),
            .fire  (fire_flat[g*GRP_LINES +: GRP_LINES])
        );

        gsvc_grp_regs #(.LINES(GRP_LINES)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (fire_flat[g*GRP_LINES +: GRP_LINES]),
            .wdata   (reg_wdata[HALF*HALF_W +: GRP_LINES]),
            .cfg_we  (wsel && (cls == CLS_CON)),
            .mask_we (wsel && (cls == CLS_MASK)),
            .pend_we (wsel && (cls == CLS_PEND)),
            .cfg_q   (con_flat[g*CFG_W +: CFG_W]),
            .mask_q  (mask_flat[g*GRP_LINES +: GRP_LINES]),
            .pend_q  (pend_flat[g*GRP_LINES +: GRP_LINES])
        );
    end

    // A line is active while pending and unmasked.
    assign active = pend_flat & ~mask_flat;

    // Raise the parent interrupt while any line is active.
    assign irq_o = |active;

    gsvc_prio #(.NUM_GROUPS(NUM_GROUPS)) u_prio (
        .active (active),
        .svc    (svc)
    );

    // Expose the service fields for the bound checker.
    assign svc_grp  = svc.grp;
    assign svc_line = svc.line;

    // Return the addressed word; unmapped or misaligned reads yield zero.
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            if (cls == CLS_SVC) begin
                reg_rdata = WORD_W'({svc.grp, svc.line});
            end else begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (widx == WIDX_W'(g / 2)) begin
                        if (cls == CLS_CON)
                            reg_rdata[(g%2)*HALF_W +: HALF_W] = con_flat[g*CFG_W +: CFG_W];
                        else if (cls == CLS_MASK)
                            reg_rdata[(g%2)*HALF_W +: HALF_W] = mask_flat[g*GRP_LINES +: GRP_LINES];
                        else
                            reg_rdata[(g%2)*HALF_W +: HALF_W] = pend_flat[g*GRP_LINES +: GRP_LINES];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/gsvc_chk.sv
// Assertion checker for the service encoder, bound to the top module.
// Relates the service fields, the parent interrupt and the register state.
module gsvc_chk
    import gsvc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            reg_we,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic                            irq_o,
    input logic [NUM_GROUPS*GRP_LINES-1:0] pend_flat,
    input logic [NUM_GROUPS*GRP_LINES-1:0] mask_flat,
    input logic [NUM_GROUPS*GRP_LINES-1:0] con_flat,
    input logic [FIELD_W-1:0]              svc_grp,
    input logic [FIELD_W-1:0]              svc_line
);
    localparam int TOTAL = NUM_GROUPS * GRP_LINES;

    logic [TOTAL-1:0] active;
    logic             svc_wr;
    logic             sel_pend;
    logic             sel_masked;
    logic             lower_busy;

    // Form the set of active lines and detect a write to the service word.
    assign active = pend_flat & ~mask_flat;
    assign svc_wr = reg_we && ((reg_addr >> (ADDR_W - 2)) == ADDR_W'(3));

    // Look up the line the service word names and any active line below it.
    always_comb begin
        int idx;
        idx        = 0;
        sel_pend   = 1'b0;
        sel_masked = 1'b0;
        lower_busy = 1'b0;
        if (svc_grp != '0 && int'(svc_grp) <= NUM_GROUPS) begin
            idx        = (int'(svc_grp) - 1) * GRP_LINES + int'(svc_line);
            sel_pend   = pend_flat[idx];
            sel_masked = mask_flat[idx];
            for (int i = 0; i < TOTAL; i++) begin
                if (i < idx && active[i]) lower_busy = 1'b1;
            end
        end
    end

    // R2
    svc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (svc_grp != '0));

    // R1
    svc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(svc_grp) <= NUM_GROUPS);

    // R7
    svc_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_grp != '0) |-> (sel_pend && !sel_masked));

    // R3
    svc_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_grp != '0) |-> !lower_busy);

    // R10
    svc_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_wr |=> ($stable(mask_flat) && $stable(con_flat)));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_flat == '0 && mask_flat == '1 && con_flat == '0));
endmodule

bind gpio_irq_svc_enc gsvc_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_irq_svc_enc_tb.sv
module gpio_irq_svc_enc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NG         = 4;
    localparam int NL         = 16;
    localparam logic [7:0] A_CON  = 8'h00;
    localparam logic [7:0] A_MASK = 8'h40;
    localparam logic [7:0] A_PEND = 8'h80;
    localparam logic [7:0] A_SVC  = 8'hC0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG*NL-1:0] line_in = '1;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = A_SVC;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    gpio_irq_svc_enc #(.NUM_GROUPS(NG), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_con  [NG];
    logic [15:0] m_mask [NG];
    logic [15:0] m_pend [NG];
    logic [NG*NL-1:0] m_prev;

    function automatic logic [31:0] m_svc();
        for (int g = 0; g < NG; g++)
            for (int l = 0; l < NL; l++)
                if (m_pend[g][l] && !m_mask[g][l]) return 32'((g + 1) * 16 + l);
        return 32'd0;
    endfunction

    function automatic logic m_irq();
        return m_svc() != 32'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                m_con[g] = '0; m_mask[g] = '1; m_pend[g] = '0;
            end
            m_prev = line_in;
        end else begin
            for (int g = 0; g < NG; g++) begin
                for (int l = 0; l < NL; l++) begin
                    int code; int cur; int pv; bit hit;
                    code = int'(m_con[g][(l/4)*4 +: 4]);
                    cur  = int'(line_in[g*NL+l]);
                    pv   = int'(m_prev[g*NL+l]);
                    hit  = (code == 0 && cur == 0) || (code == 1 && cur == 1) ||
                           ((code == 2 || code == 6) && pv == 1 && cur == 0) ||
                           ((code == 4 || code == 6) && pv == 0 && cur == 1);
                    if (reg_we && reg_addr[1:0] == 0 && int'(reg_addr[7:6]) == 2 &&
                        int'(reg_addr[5:2]) == g / 2 && reg_wdata[(g%2)*16 + l])
                        m_pend[g][l] = 1'b0;
                    if (hit) m_pend[g][l] = 1'b1;
                end
            end
            for (int g = 0; g < NG; g++) begin
                if (reg_we && reg_addr[1:0] == 0 && int'(reg_addr[5:2]) == g / 2) begin
                    if (reg_addr[7:6] == 2'd0) m_con[g]  = reg_wdata[(g%2)*16 +: 16];
                    if (reg_addr[7:6] == 2'd1) m_mask[g] = reg_wdata[(g%2)*16 +: 16];
                end
            end
            m_prev = line_in;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R9 per-cycle comparison of irq and the service word against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R9 irq vs model", 32'(irq_o), 32'(m_irq()));
            if (!reg_we && reg_addr == A_SVC)
                chk("R3 service vs model", reg_rdata, m_svc());
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = A_SVC; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic set_line(input int idx, input logic v);
        @(negedge clk);
        reg_addr = A_SVC;
        line_in[idx] = v;
    endtask

    task automatic set_two(input int a, input int b, input logic v);
        @(negedge clk);
        reg_addr = A_SVC;
        line_in[a] = v; line_in[b] = v;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        rdchk("R11 mask reset", A_MASK, 32'hFFFF_FFFF);
        rdchk("R11 pend reset", A_PEND, 32'h0);
        rdchk("R11 con reset", A_CON + 8'h04, 32'h0);
        rdchk("R2 service empty", A_SVC, 32'h0);
        chk("R2 irq low", 32'(irq_o), 32'h0);
        // R4 layout: g0 rise, g1 fall, g2 low, g3 both
        wr(A_CON, 32'h2222_4444);
        wr(A_CON + 8'h04, 32'h6666_0000);
        rdchk("R4 con word1", A_CON + 8'h04, 32'h6666_0000);
        rdchk("R4 con word0", A_CON, 32'h2222_4444);
        wr(A_MASK, 32'h0);
        wr(A_MASK + 8'h04, 32'h0);
        rdchk("R2 unmasked, idle", A_SVC, 32'h0);
        // R6 falling edge on group index 1 line 5
        set_line(16 + 5, 1'b0);
        rdchk("R1 service g2 l5", A_SVC, 32'h25);
        // R5 falling on a rising-configured line: nothing
        set_line(9, 1'b0);
        rdchk("R5 fall ignored on rise code", A_PEND, 32'h0020_0000);
        set_line(9, 1'b1);
        rdchk("R3 lower group wins", A_SVC, 32'h19);
        rdchk("R4 pend word0 halves", A_PEND, 32'h0020_0200);
        // R7 mask
        wr(A_MASK, 32'h0000_0200);
        rdchk("R7 masked line skipped", A_SVC, 32'h25);
        rdchk("R7 pend retained", A_PEND, 32'h0020_0200);
        // R8 write-one clear
        wr(A_PEND, 32'h0020_0000);
        rdchk("R9 service empty after clear", A_SVC, 32'h0);
        chk("R9 irq low after clear", 32'(irq_o), 32'h0);
        wr(A_PEND, 32'h0);
        rdchk("R8 zero write keeps pend", A_PEND, 32'h0000_0200);
        // R6 level low on group index 2 line 14
        set_line(32 + 14, 1'b0);
        rdchk("R6 level sets", A_SVC, 32'h3E);
        wr(A_PEND + 8'h04, 32'h0000_4000);
        rdchk("R8 held level wins clear", A_PEND + 8'h04, 32'h0000_4000);
        set_line(32 + 14, 1'b1);
        wr(A_PEND + 8'h04, 32'h0000_4000);
        rdchk("R8 clear after release", A_PEND + 8'h04, 32'h0);
        // R5 both edges on group index 3 line 0
        set_line(48, 1'b0);
        rdchk("R5 both falling", A_SVC, 32'h40);
        wr(A_PEND + 8'h04, 32'h0001_0000);
        set_line(48, 1'b1);
        rdchk("R5 both rising", A_PEND + 8'h04, 32'h0001_0000);
        wr(A_PEND + 8'h04, 32'h0001_0000);
        // R3 within-group priority and R9 advance
        set_two(48 + 2, 48 + 7, 1'b0);
        rdchk("R3 lowest line", A_SVC, 32'h42);
        wr(A_PEND + 8'h04, 32'h0004_0000);
        rdchk("R9 advances to next", A_SVC, 32'h47);
        wr(A_PEND + 8'h04, 32'h0080_0000);
        rdchk("R9 empty again", A_SVC, 32'h0);
        // R5 unused code 3
        wr(A_CON + 8'h04, 32'h6663_0000);
        set_line(48 + 1, 1'b0);
        set_line(48 + 1, 1'b1);
        rdchk("R5 unused code silent", A_PEND + 8'h04, 32'h0);
        // R10 service writes and unmapped reads
        wr(A_SVC, 32'hFFFF_FFFF);
        rdchk("R10 mask kept", A_MASK, 32'h0000_0200);
        rdchk("R10 con kept", A_CON + 8'h04, 32'h6663_0000);
        rdchk("R10 unmapped word", A_CON + 8'h08, 32'h0);
        rdchk("R10 misaligned", A_MASK + 8'h01, 32'h0);
        wr(A_MASK + 8'h01, 32'h0);
        rdchk("R10 misaligned write ignored", A_MASK, 32'h0000_0200);
        // R7 unmask brings retained line back
        wr(A_MASK, 32'h0);
        rdchk("R7 unmask restores", A_SVC, 32'h19);
        chk("R9 irq high", 32'(irq_o), 32'h1);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule